// File: doc/BRIEF.md
# Host Memory Window Bridge

The bridge gives a host on a simple synchronous byte bus a window into a word-organised internal memory. The window consists of eight byte registers:

- two mailbox bytes, one per direction;
- two address bytes that also carry an access type;
- four data-lane bytes that move one word through a 32-bit staging register.

Software sets a word address and an access type first. It then reads or writes the data lanes. Depending on the access type, a lane access either touches memory directly or works through the staging register.

In the 32-bit types, the loads and commits are tied to fixed lanes. A read of lane 0 pulls the whole word into staging. A write of lane 3 pushes all four staged bytes to memory. The 16-bit type does the same per half-word. In the auto-increment type, every access to lane 3 moves the address on by one word. A whole block can therefore be streamed with nothing but data-lane accesses. The word address wraps within the memory. Address bits above the memory size are kept in the address register but do not select a word.

The two mailboxes carry single-byte messages between the host and the embedded side. Each mailbox has a full flag. The writer of a mailbox sets its flag, and a read by the receiver clears it.

Top module: `hmw_bridge`

## Requirements
- R1: Register offsets on `h_addr`:
  - 0 is the host-to-embedded mailbox and 1 is the embedded-to-host mailbox.
  - 2 is address low and 3 is address high.
  - 4 to 7 are data lanes 0 to 3, where lane n is bits 8n+7:8n of a word.
  - Read data appears on `h_rdata` in the cycle after the read strobe and holds until the next read.
- R2: Address low register:
  - Bits 1:0 hold the access type: 0 byte, 1 half-word, 2 word, 3 word with auto-increment.
  - Bits 7:2 hold byte-address bits 7:2, which are word-address bits 5:0.
  - A read returns the current address bits and access type.
- R3: Address high register:
  - Bits 6:0 hold byte-address bits 14:8, which are word-address bits 12:6.
  - A write to bit 7 is ignored, and bit 7 reads as 0.
- R4: Byte type: a data-lane read returns that lane of the addressed word, and a lane write changes only that lane in memory.
- R5: Half-word type:
  - A read of lane 0 stages the lower half, and a read of lane 2 stages the upper half. Reads of lanes 1 and 3 return staged bytes.
  - A write of lane 1 commits the lower half, and a write of lane 3 commits the upper half. Writes of lanes 0 and 2 only stage.
- R6: Word types: a read of lane 0 loads the whole addressed word into staging and returns byte 0. Reads of lanes 1 to 3 return the staged bytes.
- R7: Word types: writes of lanes 0 to 2 change only staging and leave memory unchanged. A write of lane 3 commits {lane 3 data, staged bytes 2..0} to the addressed word.
- R8: Auto-increment type: each read or write of lane 3 advances the word address by one after the access. Other types never change the address.
- R9: The memory holds DEPTH = 2^AW words (default 256). Only word-address bits AW-1:0 select a word, and an increment wraps those bits to zero while the upper address bits stay unchanged.
- R10: Host-to-embedded mailbox:
  - A host write of offset 0 stores the byte and sets `h2e_full`.
  - A pulse on `e_h2e_rd` clears the flag, but a host write in the same cycle wins.
  - A host read of offset 0 returns the stored byte.
- R11: Embedded-to-host mailbox:
  - A pulse on `e_e2h_wr` stores `e_e2h_wdata` and sets `e2h_full`.
  - A host read of offset 1 returns the byte and clears the flag.
  - Host writes to offset 1 are ignored.
- R12: After reset:
  - both flags, both mailbox bytes, the address, the access type and `h_rdata` are zero;
  - the staging register is zero;
  - memory content is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host register offset |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| e_h2e_rd | input | 1 | Embedded side consumes the host-to-embedded mailbox |
| e_h2e_data | output | 8 | Host-to-embedded mailbox content |
| h2e_full | output | 1 | Host-to-embedded mailbox holds an unread byte |
| e_e2h_wr | input | 1 | Embedded side writes the embedded-to-host mailbox |
| e_e2h_wdata | input | 8 | Embedded-to-host mailbox write data |
| e2h_full | output | 1 | Embedded-to-host mailbox holds an unread byte |

## Verification
The assertions assume that the host never raises its read and write strobes in the same cycle. Every access is a single-cycle strobe, with address and data stable only while it is high. The bench drives every access through one task per direction that raises one strobe at a falling edge and drops it at the next falling edge. It therefore never overlaps a read and a write. Before reading any word, the bench fills the whole memory through the auto-increment type, so no property or expected value depends on uninitialised memory.

// File: rtl/hmw_pkg.sv
package hmw_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'd0,
    ACC_HALF     = 2'd1,
    ACC_WORD     = 2'd2,
    ACC_WORD_INC = 2'd3
  } acc_e;

  // word-address width fixed by the two address registers (bits 14:2)
  localparam int WORD_ADDR_W = 13;

  localparam logic [2:0] OFS_H2E  = 3'd0;
  localparam logic [2:0] OFS_E2H  = 3'd1;
  localparam logic [2:0] OFS_ALO  = 3'd2;
  localparam logic [2:0] OFS_AHI  = 3'd3;

endpackage

// File: rtl/hmw_mailbox.sv
module hmw_mailbox #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);

  logic [DW-1:0] data_q, data_d;
  logic          full_q, full_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    if (clr_i) full_d = 1'b0;
    if (set_i) begin
      full_d = 1'b1;
      data_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (set_i) data_q <= data_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  // R10 and R11 (one instance each): writer raises the flag and stores the byte
  a_r10_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (full_o && data_o == $past(wdata_i)));
  // R10 and R11: a read by the receiver clears the flag unless a set collides
  a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !full_o);

endmodule

// File: rtl/hmw_addr_ctl.sv
module hmw_addr_ctl
  import hmw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [7:0]    lo_wdata_i,
  input  logic [6:0]    hi_wdata_i,
  input  logic          step_i,
  output acc_e          mode_o,
  output logic [AW-1:0] idx_o,
  output logic [7:0]    lo_byte_o,
  output logic [7:0]    hi_byte_o
);

  logic [WORD_ADDR_W-1:0] word_q, word_d;
  acc_e                   mode_q, mode_d;
  logic                   upd;

  always_comb begin
    word_d = word_q;
    mode_d = mode_q;
    if (wr_lo_i) begin
      word_d[5:0] = lo_wdata_i[7:2];
      mode_d      = acc_e'(lo_wdata_i[1:0]);
    end
    if (wr_hi_i) word_d[12:6] = hi_wdata_i;
    if (step_i)  word_d[AW-1:0] = word_q[AW-1:0] + 1'b1;
  end

  assign upd = wr_lo_i | wr_hi_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= ACC_BYTE;
    end else if (upd) begin
      word_q <= word_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o    = mode_q;
  assign idx_o     = word_q[AW-1:0];
  assign lo_byte_o = {word_q[5:0], mode_q};
  assign hi_byte_o = {1'b0, word_q[12:6]};

  // R8/R9: an increment moves the memory index by exactly one word, wrapping
  a_r8_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> idx_o == $past(idx_o) + 1'b1);
  // R8: without an address write or increment the address stays put
  a_r8_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo_i || wr_hi_i || step_i) |=> ($stable(idx_o) && $stable(hi_byte_o)));
  // R2: the access type follows the low address write
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> mode_o == acc_e'($past(lo_wdata_i[1:0])));

endmodule

// File: rtl/hmw_datapath.sv
module hmw_datapath
  import hmw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [1:0]    lane_i,
  input  logic [7:0]    wdata_i,
  input  acc_e          mode_i,
  input  logic [AW-1:0] idx_i,
  output logic [7:0]    rbyte_o,
  output logic          step_o
);

  localparam int DEPTH = 1 << AW;
  localparam int LANES = 4;

  logic [31:0]      mem_q [DEPTH];
  logic [31:0]      stage_q, stage_d;
  logic [31:0]      word_w;
  logic [7:0]       mem_lane;
  logic [LANES-1:0] be;
  logic [31:0]      wd;
  logic             is_word;

  assign word_w   = mem_q[idx_i];
  assign mem_lane = word_w[8*lane_i +: 8];
  assign is_word  = (mode_i == ACC_WORD) || (mode_i == ACC_WORD_INC);

  always_comb begin
    stage_d = stage_q;
    be      = '0;
    wd      = '0;
    rbyte_o = stage_q[8*lane_i +: 8];
    unique case (mode_i)
      ACC_BYTE: begin
        rbyte_o = mem_lane;
        if (wr_i) begin
          be[lane_i]         = 1'b1;
          wd[8*lane_i +: 8]  = wdata_i;
        end
      end
      ACC_HALF: begin
        if (!lane_i[0]) begin
          rbyte_o = mem_lane;
          if (rd_i) stage_d[16*lane_i[1] +: 16] = word_w[16*lane_i[1] +: 16];
        end
        if (wr_i) begin
          stage_d[8*lane_i +: 8] = wdata_i;
          if (lane_i[0]) begin
            be[2*lane_i[1] +: 2]  = 2'b11;
            wd[16*lane_i[1] +: 16] = {wdata_i, stage_q[16*lane_i[1] +: 8]};
          end
        end
      end
      default: begin
        if (lane_i == 2'd0) begin
          rbyte_o = mem_lane;
          if (rd_i) stage_d = word_w;
        end
        if (wr_i) begin
          stage_d[8*lane_i +: 8] = wdata_i;
          if (lane_i == 2'd3) begin
            be = '1;
            wd = {wdata_i, stage_q[23:0]};
          end
        end
      end
    endcase
  end

  assign step_o = (mode_i == ACC_WORD_INC) && (rd_i || wr_i) && (lane_i == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (rd_i || wr_i) stage_q <= stage_d;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (be[b]) mem_q[idx_i][8*b +: 8] <= wd[8*b +: 8];
    end
  end

  // R6: a lane-0 read in a word type captures the addressed word in staging
  a_r6_stage_load: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && is_word && lane_i == 2'd0) |=> stage_q == $past(word_w));
  // R7: a lane-3 write in a word type lands the staged bytes plus new top byte
  a_r7_commit_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && is_word && lane_i == 2'd3) |=>
      mem_q[$past(idx_i)] == {$past(wdata_i), $past(stage_q[23:0])});
  // R7: lower-lane writes in a word type leave the addressed word untouched
  a_r7_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && is_word && lane_i != 2'd3) |=> mem_q[$past(idx_i)] == $past(word_w));

endmodule

// File: rtl/hmw_bridge.sv
module hmw_bridge
  import hmw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] h_addr,
  input  logic       h_rd,
  input  logic       h_wr,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  input  logic       e_h2e_rd,
  output logic [7:0] e_h2e_data,
  output logic       h2e_full,
  input  logic       e_e2h_wr,
  input  logic [7:0] e_e2h_wdata,
  output logic       e2h_full
);

  logic       sel_data;
  logic [1:0] lane;
  logic       dp_rd, dp_wr, step;
  acc_e       mode;
  logic [AW-1:0] idx;
  logic [7:0] lo_byte, hi_byte, dp_rbyte, e2h_data;
  logic [7:0] rdata_q, rdata_d;

  assign sel_data = h_addr[2];
  assign lane     = h_addr[1:0];
  assign dp_rd    = h_rd && sel_data;
  assign dp_wr    = h_wr && sel_data;

  hmw_mailbox #(.DW(8)) u_h2e (
    .clk(clk), .rst_n(rst_n),
    .set_i(h_wr && h_addr == OFS_H2E), .wdata_i(h_wdata),
    .clr_i(e_h2e_rd),
    .data_o(e_h2e_data), .full_o(h2e_full)
  );

  hmw_mailbox #(.DW(8)) u_e2h (
    .clk(clk), .rst_n(rst_n),
    .set_i(e_e2h_wr), .wdata_i(e_e2h_wdata),
    .clr_i(h_rd && h_addr == OFS_E2H),
    .data_o(e2h_data), .full_o(e2h_full)
  );

  hmw_addr_ctl #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_lo_i(h_wr && h_addr == OFS_ALO),
    .wr_hi_i(h_wr && h_addr == OFS_AHI),
    .lo_wdata_i(h_wdata), .hi_wdata_i(h_wdata[6:0]),
    .step_i(step),
    .mode_o(mode), .idx_o(idx),
    .lo_byte_o(lo_byte), .hi_byte_o(hi_byte)
  );

  hmw_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .rd_i(dp_rd), .wr_i(dp_wr), .lane_i(lane), .wdata_i(h_wdata),
    .mode_i(mode), .idx_i(idx),
    .rbyte_o(dp_rbyte), .step_o(step)
  );

  always_comb begin
    unique case (h_addr)
      OFS_H2E: rdata_d = e_h2e_data;
      OFS_E2H: rdata_d = e2h_data;
      OFS_ALO: rdata_d = lo_byte;
      OFS_AHI: rdata_d = hi_byte;
      default: rdata_d = dp_rbyte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (h_rd) rdata_q <= rdata_d;
  end

  assign h_rdata = rdata_q;

  // R1: host strobes are exclusive (input assumption)
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_rd && h_wr));
  // R1: read data only changes after a read strobe
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> $stable(h_rdata));
  // R3: high address bit 7 always reads back as zero after a read of offset 3
  a_r3_hi_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == OFS_AHI) |=> !h_rdata[7]);

endmodule

// File: tb/hmw_bridge_test.sv
`timescale 1ns/1ps
module hmw_bridge_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] h_addr;
  logic       h_rd, h_wr;
  logic [7:0] h_wdata, h_rdata;
  logic       e_h2e_rd, e_e2h_wr;
  logic [7:0] e_h2e_data, e_e2h_wdata;
  logic       h2e_full, e2h_full;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] mdl [256];

  always #2.5 clk = ~clk;

  hmw_bridge #(.AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .e_h2e_rd(e_h2e_rd),
    .e_h2e_data(e_h2e_data), .h2e_full(h2e_full), .e_e2h_wr(e_e2h_wr),
    .e_e2h_wdata(e_e2h_wdata), .e2h_full(e2h_full)
  );

  function automatic logic [7:0] lo_of(input logic [12:0] w, input logic [1:0] m);
    return {w[5:0], m};
  endfunction
  function automatic logic [7:0] hi_of(input logic [12:0] w);
    return {1'b0, w[12:6]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0; d = h_rdata;
  endtask

  task automatic set_addr(input logic [12:0] w, input logic [1:0] m);
    hw(3'd2, lo_of(w, m));
    hw(3'd3, hi_of(w));
  endtask

  task automatic rd_word(output logic [31:0] v);
    logic [7:0] b;
    for (int l = 0; l < 4; l++) begin
      hr(3'(4 + l), b);
      v[8*l +: 8] = b;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v, e;
    logic [12:0] w;
    logic [1:0]  ln;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; h_addr = '0; h_rd = 0; h_wr = 0; h_wdata = '0;
    e_h2e_rd = 0; e_e2h_wr = 0; e_e2h_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R12 rdata at reset", h_rdata, 0);
    chk("R12 flags at reset", {h2e_full, e2h_full}, 0);
    rst_n = 1'b1;
    hr(3'd2, b); chk("R12 addr lo after reset", b, 0);
    hr(3'd3, b); chk("R12 addr hi after reset", b, 0);
    hr(3'd0, b); chk("R12 h2e byte after reset", b, 0);

    // R8 fill whole memory by streaming lanes in auto-increment type
    set_addr(13'd0, 2'd3);
    for (int i = 0; i < 256; i++) begin
      mdl[i] = $urandom;
      for (int l = 0; l < 4; l++) hw(3'(4 + l), mdl[i][8*l +: 8]);
    end
    // R9 wrap back to word 0
    hr(3'd2, b); chk("R9 addr lo after wrap", b, lo_of(13'd0, 2'd3));
    hr(3'd3, b); chk("R9 addr hi after wrap", b, 0);

    // R6 random word reads
    for (int k = 0; k < 30; k++) begin
      w = 13'($urandom % 256);
      set_addr(w, 2'd2);
      rd_word(v);
      chk("R6 word read", v, mdl[w]);
    end
    // R8 word type (no increment) keeps address
    hr(3'd2, b); chk("R8 no advance in word type", b, lo_of(w, 2'd2));

    // R4 byte type random reads and writes
    for (int k = 0; k < 20; k++) begin
      w = 13'($urandom % 256);
      ln = 2'($urandom);
      set_addr(w, 2'd0);
      hr(3'(4 + ln), b); chk("R4 byte read", b, mdl[w][8*ln +: 8]);
      b = 8'($urandom);
      hw(3'(4 + ln), b);
      mdl[w][8*ln +: 8] = b;
      set_addr(w, 2'd2);
      rd_word(v); chk("R4 byte write lane only", v, mdl[w]);
    end

    // R5 half-word type
    w = 13'd17;
    set_addr(w, 2'd1);
    hr(3'd4, b); chk("R5 half lane0 read", b, mdl[w][7:0]);
    hr(3'd5, b); chk("R5 half lane1 staged", b, mdl[w][15:8]);
    hr(3'd6, b); chk("R5 half lane2 read", b, mdl[w][23:16]);
    hr(3'd7, b); chk("R5 half lane3 staged", b, mdl[w][31:24]);
    hw(3'd6, 8'hC3);
    set_addr(w, 2'd2); rd_word(v); chk("R5 lane2 write only stages", v, mdl[w]);
    set_addr(w, 2'd1);
    hw(3'd4, 8'h11); hw(3'd5, 8'h22);
    mdl[w][15:0] = 16'h2211;
    set_addr(w, 2'd2); rd_word(v); chk("R5 lower half commit", v, mdl[w]);
    set_addr(w, 2'd1);
    hw(3'd6, 8'h33); hw(3'd7, 8'h44);
    mdl[w][31:16] = 16'h4433;
    set_addr(w, 2'd2); rd_word(v); chk("R5 upper half commit", v, mdl[w]);

    // R7 staged writes, then commit
    w = 13'd200;
    set_addr(w, 2'd2);
    hw(3'd4, 8'hA1); hw(3'd5, 8'hB2); hw(3'd6, 8'hC3);
    hw(3'd2, lo_of(w, 2'd0));
    hr(3'd4, b); chk("R7 lanes 0-2 do not commit", b, mdl[w][7:0]);
    hr(3'd6, b); chk("R7 lane 2 not committed", b, mdl[w][23:16]);
    hw(3'd2, lo_of(w, 2'd2));
    hw(3'd7, 8'hD4);
    mdl[w] = 32'hD4C3B2A1;
    rd_word(v); chk("R7 lane3 commits word", v, mdl[w]);

    // R8 auto-increment reads over two words
    w = 13'd40;
    set_addr(w, 2'd3);
    rd_word(v); chk("R8 auto read word 0", v, mdl[40]);
    rd_word(v); chk("R8 auto read word 1", v, mdl[41]);
    hr(3'd2, b); chk("R8 address advanced by two", b, lo_of(13'd42, 2'd3));

    // R9 alias and wrap with upper bits held
    w = 13'h4FF;
    set_addr(w, 2'd3);
    rd_word(v); chk("R9 upper bits ignored", v, mdl[255]);
    hr(3'd2, b); chk("R9 wrap lo", b, lo_of(13'h400, 2'd3));
    hr(3'd3, b); chk("R9 upper held", b, hi_of(13'h400));
    rd_word(v); chk("R9 wrapped word", v, mdl[0]);

    // R3 bit 7 ignored
    hw(3'd3, 8'h85);
    hr(3'd3, b); chk("R3 hi bit7 ignored", b, 8'h05);

    // R10 host-to-embedded mailbox
    hw(3'd0, 8'h5A);
    chk("R10 flag set", h2e_full, 1);
    chk("R10 data to embedded", e_h2e_data, 8'h5A);
    hr(3'd0, b); chk("R10 host readback", b, 8'h5A);
    @(negedge clk); e_h2e_rd = 1;
    @(negedge clk); e_h2e_rd = 0;
    chk("R10 embedded read clears", h2e_full, 0);
    @(negedge clk); e_h2e_rd = 1; h_addr = 3'd0; h_wdata = 8'h77; h_wr = 1;
    @(negedge clk); e_h2e_rd = 0; h_wr = 0;
    chk("R10 set wins over clear", h2e_full, 1);

    // R11 embedded-to-host mailbox
    @(negedge clk); e_e2h_wdata = 8'h3C; e_e2h_wr = 1;
    @(negedge clk); e_e2h_wr = 0;
    chk("R11 flag set", e2h_full, 1);
    hw(3'd1, 8'hFF);
    chk("R11 host write keeps flag", e2h_full, 1);
    hr(3'd1, b); chk("R11 host write ignored", b, 8'h3C);
    chk("R11 host read clears", e2h_full, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule